// File: doc/BRIEF.md
# Match-Capture Timer with Prescaler

A word-addressed timer/counter peripheral built around a 32-bit count register. In timer mode a prescaler divides the clock by a programmable value plus one and each wrap advances the main count. In counter mode the main count advances instead on rising, falling or both edges of one selected capture input, after that input has passed through a two-flop synchroniser.

Four match channels compare the count against their own value at every count step. A hit can raise an interrupt flag, return the count to zero, stop the count, and drive a match output pin through a per-channel clear/set/toggle action. Four capture channels copy the count into a read-only register on a chosen edge of their input and may raise their own flag. A single interrupt line is the OR of eight sticky flags, and software clears each flag by writing a one to it.

Top module: `match_capture_timer`

## Requirements
- R1: After reset every register reads zero, `irq` is 0 and `match_out` is 0.
- R2: Byte offsets: flags 0x00, control 0x04, count 0x08, prescale 0x0C, prescale count 0x10, match control 0x14, match values 0x18+4n, capture control 0x28, capture values 0x2C+4n (read-only), match output 0x3C, count mode 0x70; writes land on the clock edge, reads are combinational and zero-extended, unused bits read 0.
- R3: While control bit 0 (run) is clear, the count and prescale count change only by a write or by control bit 1.
- R4: Count mode bits 1:0 = 0 selects timer mode: with run set, the prescale count steps by one per clock and, on a clock where it equals the prescale value, wraps to 0 and makes a count step.
- R5: At a count step where the count equals match value n, match control bit 3n sets flag bit n and bit 3n+1 makes the next count 0; with both set, flag n first rises (P+1)(M+1) clocks after run is set from a held-at-zero state.
- R6: Match control bit 3n+2 makes a hit hold the count at its value and clear control bit 0; a hit without bit 3n sets no flag.
- R7: Match output register bits 3:0 drive `match_out`; the 2-bit field at bit 4+2n applies on a hit of channel n: 0 keep, 1 clear, 2 set, 3 toggle.
- R8: Capture control bit 3n captures on a rising edge of `cap_in[n]`, bit 3n+1 on a falling edge, bit 3n+2 also sets flag bit 4+n; the capture register takes the current count whether running or not; a disabled edge leaves it unchanged.
- R9: Count mode bits 1:0 = 1, 2, 3 count rising, falling or both edges of the input chosen by bits 3:2, and edges on other inputs do not count.
- R10: Writing a one to a flag bit clears it, zeros leave it; a hardware set in the same clock wins; `irq` is high while any flag is set.
- R11: While control bit 1 is set, the count and prescale count are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register at bus_addr |
| bus_addr | input | 7 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| cap_in | input | 4 | Capture / count inputs, asynchronous |
| match_out | output | 4 | Match output pins |
| irq | output | 1 | Interrupt, OR of all flags |

## Verification
On every cycle the assertions check that the count is frozen while stopped, that it only ever steps by one, stays put or returns to zero while running, that the hold bit pins both counters to zero, that a pending flag keeps the interrupt asserted, and that capture registers never move while every capture edge is disabled. Only the bench scenarios show the arithmetic: the match period for each prescale and match value pair, the order of edge handling in each count mode and input selection, each of the four output actions, and the exact count copied by every capture configuration.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NCH = 4;
  localparam int AW  = 7;

  localparam logic [AW-1:0] A_FLAG = 7'h00;
  localparam logic [AW-1:0] A_CTRL = 7'h04;
  localparam logic [AW-1:0] A_TC   = 7'h08;
  localparam logic [AW-1:0] A_PR   = 7'h0C;
  localparam logic [AW-1:0] A_PC   = 7'h10;
  localparam logic [AW-1:0] A_MCR  = 7'h14;
  localparam logic [AW-1:0] A_MR0  = 7'h18;
  localparam logic [AW-1:0] A_CCR  = 7'h28;
  localparam logic [AW-1:0] A_CR0  = 7'h2C;
  localparam logic [AW-1:0] A_EMR  = 7'h3C;
  localparam logic [AW-1:0] A_CTCR = 7'h70;

  typedef enum logic [1:0] {CM_TIMER, CM_RISE, CM_FALL, CM_BOTH} cnt_mode_e;
  typedef enum logic [1:0] {EA_KEEP, EA_CLR, EA_SET, EA_TGL} ext_act_e;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [SYNC_STAGES:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[SYNC_STAGES-1:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise =  sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
  assign fall = ~sh_q[SYNC_STAGES-1] &  sh_q[SYNC_STAGES];
endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen import tmr_pkg::*; #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  cnt_mode_e        mode,
  input  logic             src_rise,
  input  logic             src_fall,
  input  logic [CNT_W-1:0] pr,
  input  logic             pc_wr,
  input  logic [CNT_W-1:0] pc_wdata,
  output logic [CNT_W-1:0] pc_q,
  output logic             tick
);
  logic [CNT_W-1:0] pc_d;
  logic             wrap;

  assign wrap = (pc_q == pr);

  always_comb begin
    tick = 1'b0;
    if (run && !hold) begin
      case (mode)
        CM_TIMER: tick = wrap;
        CM_RISE:  tick = src_rise;
        CM_FALL:  tick = src_fall;
        default:  tick = src_rise | src_fall;
      endcase
    end
  end

  always_comb begin
    pc_d = pc_q;
    if (hold)                           pc_d = '0;
    else if (pc_wr)                     pc_d = pc_wdata;
    else if (run && mode == CM_TIMER)   pc_d = wrap ? '0 : pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/tmr_match_unit.sv
module tmr_match_unit import tmr_pkg::*; #(
  parameter int CNT_W = 32
) (
  input  logic                      tick,
  input  logic [CNT_W-1:0]          tc,
  input  logic [NCH-1:0][CNT_W-1:0] mr,
  input  logic [3*NCH-1:0]          mcr,
  input  logic [NCH-1:0]            pin_cur,
  input  logic [2*NCH-1:0]          pin_act,
  output logic [NCH-1:0]            flag_set,
  output logic                      zero_req,
  output logic                      stop_req,
  output logic [NCH-1:0]            pin_nxt
);
  logic [NCH-1:0] hit, zero_v, stop_v;

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign hit[n]      = tick && (tc == mr[n]);
    assign flag_set[n] = hit[n] & mcr[3*n];
    assign zero_v[n]   = hit[n] & mcr[3*n+1];
    assign stop_v[n]   = hit[n] & mcr[3*n+2];

    always_comb begin
      pin_nxt[n] = pin_cur[n];
      if (hit[n]) begin
        case (ext_act_e'(pin_act[2*n +: 2]))
          EA_CLR:  pin_nxt[n] = 1'b0;
          EA_SET:  pin_nxt[n] = 1'b1;
          EA_TGL:  pin_nxt[n] = ~pin_cur[n];
          default: pin_nxt[n] = pin_cur[n];
        endcase
      end
    end
  end

  assign zero_req = |zero_v;
  assign stop_req = |stop_v;
endmodule

// File: rtl/match_capture_timer.sv
module match_capture_timer import tmr_pkg::*; #(
  parameter int CNT_W       = 32,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NCH-1:0]    cap_in,
  output logic [NCH-1:0]    match_out,
  output logic              irq
);
  localparam int CFG_W = 3 * NCH;
  localparam int FLG_W = 2 * NCH;
  localparam int SEL_W = $clog2(NCH);

  logic [1:0]                ctrl_q, ctrl_d;
  logic [CNT_W-1:0]          tc_q, tc_d, pr_q, pr_d, pc_q;
  logic [CFG_W-1:0]          mcr_q, mcr_d, ccr_q, ccr_d, emr_q, emr_d, emr_wv;
  logic [3:0]                ctcr_q, ctcr_d;
  logic [FLG_W-1:0]          flags_q, flags_d, flag_clr;
  logic [NCH-1:0][CNT_W-1:0] mr_q, cr_q;
  logic [NCH-1:0]            rise, fall, cap_evt, cap_flag, m_flag, pin_nxt;
  logic                      tick, zero_req, stop_req, hold, run;

  assign hold = ctrl_q[1];
  assign run  = ctrl_q[0];

  for (genvar n = 0; n < NCH; n++) begin : g_cap
    tmr_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .din(cap_in[n]), .rise(rise[n]), .fall(fall[n]));

    assign cap_evt[n]  = (ccr_q[3*n] & rise[n]) | (ccr_q[3*n+1] & fall[n]);
    assign cap_flag[n] = cap_evt[n] & ccr_q[3*n+2];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cr_q[n] <= '0;
      else if (cap_evt[n]) cr_q[n] <= tc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mr_q[n] <= '0;
      else if (bus_wr && bus_addr == A_MR0 + AW'(4*n)) mr_q[n] <= bus_wdata[CNT_W-1:0];
    end
  end

  tmr_tick_gen #(.CNT_W(CNT_W)) tick_i (
    .clk(clk), .rst_n(rst_n), .run(run), .hold(hold),
    .mode(cnt_mode_e'(ctcr_q[1:0])),
    .src_rise(rise[ctcr_q[2 +: SEL_W]]), .src_fall(fall[ctcr_q[2 +: SEL_W]]),
    .pr(pr_q), .pc_wr(bus_wr && bus_addr == A_PC),
    .pc_wdata(bus_wdata[CNT_W-1:0]), .pc_q(pc_q), .tick(tick));

  tmr_match_unit #(.CNT_W(CNT_W)) match_i (
    .tick(tick), .tc(tc_q), .mr(mr_q), .mcr(mcr_q),
    .pin_cur(emr_wv[NCH-1:0]), .pin_act(emr_wv[CFG_W-1:NCH]),
    .flag_set(m_flag), .zero_req(zero_req), .stop_req(stop_req), .pin_nxt(pin_nxt));

  // next-state logic for the register file
  always_comb begin
    ctrl_d = ctrl_q;
    pr_d   = pr_q;
    mcr_d  = mcr_q;
    ccr_d  = ccr_q;
    ctcr_d = ctcr_q;
    emr_wv = emr_q;
    flag_clr = '0;
    if (bus_wr) begin
      case (bus_addr)
        A_CTRL: ctrl_d   = bus_wdata[1:0];
        A_PR:   pr_d     = bus_wdata[CNT_W-1:0];
        A_MCR:  mcr_d    = bus_wdata[CFG_W-1:0];
        A_CCR:  ccr_d    = bus_wdata[CFG_W-1:0];
        A_CTCR: ctcr_d   = bus_wdata[3:0];
        A_EMR:  emr_wv   = bus_wdata[CFG_W-1:0];
        A_FLAG: flag_clr = bus_wdata[FLG_W-1:0];
        default: ;
      endcase
    end
    if (stop_req && !(bus_wr && bus_addr == A_CTRL)) ctrl_d[0] = 1'b0;
    emr_d   = {emr_wv[CFG_W-1:NCH], pin_nxt};
    flags_d = (flags_q & ~flag_clr) | {cap_flag, m_flag};

    tc_d = tc_q;
    if (hold)                               tc_d = '0;
    else if (bus_wr && bus_addr == A_TC)    tc_d = bus_wdata[CNT_W-1:0];
    else if (tick && zero_req)              tc_d = '0;
    else if (tick && !stop_req)             tc_d = tc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      tc_q    <= '0;
      pr_q    <= '0;
      mcr_q   <= '0;
      ccr_q   <= '0;
      emr_q   <= '0;
      ctcr_q  <= '0;
      flags_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      tc_q    <= tc_d;
      pr_q    <= pr_d;
      mcr_q   <= mcr_d;
      ccr_q   <= ccr_d;
      emr_q   <= emr_d;
      ctcr_q  <= ctcr_d;
      flags_q <= flags_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_FLAG: bus_rdata = DATA_W'(flags_q);
      A_CTRL: bus_rdata = DATA_W'(ctrl_q);
      A_TC:   bus_rdata = DATA_W'(tc_q);
      A_PR:   bus_rdata = DATA_W'(pr_q);
      A_PC:   bus_rdata = DATA_W'(pc_q);
      A_MCR:  bus_rdata = DATA_W'(mcr_q);
      A_CCR:  bus_rdata = DATA_W'(ccr_q);
      A_EMR:  bus_rdata = DATA_W'(emr_q);
      A_CTCR: bus_rdata = DATA_W'(ctcr_q);
      default: ;
    endcase
    for (int n = 0; n < NCH; n++) begin
      if (bus_addr == A_MR0 + AW'(4*n)) bus_rdata = DATA_W'(mr_q[n]);
      if (bus_addr == A_CR0 + AW'(4*n)) bus_rdata = DATA_W'(cr_q[n]);
    end
  end

  assign match_out = emr_q[NCH-1:0];
  assign irq       = |flags_q;
endmodule

// File: rtl/match_capture_timer_chk.sv
module match_capture_timer_chk import tmr_pkg::*; #(
  parameter int CNT_W = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_wr,
  input logic [AW-1:0]             bus_addr,
  input logic [1:0]                ctrl_q,
  input logic [CNT_W-1:0]          tc_q,
  input logic [CNT_W-1:0]          pc_q,
  input logic [2*NCH-1:0]          flags_q,
  input logic [3*NCH-1:0]          ccr_q,
  input logic [NCH-1:0][CNT_W-1:0] cr_q,
  input logic                      irq
);
  logic tc_wr, pc_wr, flag_wr;
  assign tc_wr   = bus_wr && bus_addr == A_TC;
  assign pc_wr   = bus_wr && bus_addr == A_PC;
  assign flag_wr = bus_wr && bus_addr == A_FLAG;

  // R3: stopped count does not move
  a_r3_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[0] && !ctrl_q[1] && !tc_wr && !pc_wr) |=> ($stable(tc_q) && $stable(pc_q)));

  // R4: a running count steps by one, holds, or returns to zero
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[1] && !tc_wr) |=>
      (tc_q == $past(tc_q) + 1'b1 || tc_q == $past(tc_q) || tc_q == '0));

  // R11: hold bit pins both counters to zero
  a_r11_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[1] |=> (tc_q == '0 && pc_q == '0));

  // R10: a pending flag that is not written keeps the interrupt up
  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q != '0 && !flag_wr) |=> irq);

  // R8: no capture register moves while every capture edge is disabled
  a_r8_cap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ccr_q == '0) |=> $stable(cr_q));
endmodule

bind match_capture_timer match_capture_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .ctrl_q(ctrl_q), .tc_q(tc_q), .pc_q(pc_q), .flags_q(flags_q),
  .ccr_q(ccr_q), .cr_q(cr_q), .irq(irq));

// File: tb/match_capture_timer_tb_top.sv
module match_capture_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  cap_in = '0;
  logic [3:0]  match_out;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  match_capture_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
    .match_out(match_out), .irq(irq));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic expect_reg(input logic [6:0] a, input logic [31:0] e, input string tag);
    logic [31:0] v;
    rd(a, v);
    check(v == e, tag, v, e);
  endtask

  task automatic idle(input int c);
    repeat (c) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [6:0] regs [16];
    regs = '{7'h00, 7'h04, 7'h08, 7'h0C, 7'h10, 7'h14, 7'h18, 7'h1C,
             7'h20, 7'h24, 7'h28, 7'h2C, 7'h30, 7'h34, 7'h3C, 7'h70};
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    foreach (regs[i]) expect_reg(regs[i], 32'h0, "R1 reset read");
    check(irq == 1'b0 && match_out == 4'h0, "R1 irq/match_out", {27'h0, irq, match_out}, 32'h0);

    // R2 register map and readback
    wr(7'h0C, 32'hDEAD_BEEF); expect_reg(7'h0C, 32'hDEAD_BEEF, "R2 prescale");
    wr(7'h10, 32'h0000_1234); expect_reg(7'h10, 32'h0000_1234, "R2 prescale count");
    wr(7'h08, 32'hCAFE_0001); expect_reg(7'h08, 32'hCAFE_0001, "R2 count");
    for (int n = 0; n < 4; n++) begin
      wr(7'h18 + 7'(4*n), 32'h100 + 32'(n));
      expect_reg(7'h18 + 7'(4*n), 32'h100 + 32'(n), "R2 match value");
    end
    wr(7'h14, 32'hFFFF_FFFF); expect_reg(7'h14, 32'h0FFF, "R2 match control width");
    wr(7'h28, 32'hFFFF_FFFF); expect_reg(7'h28, 32'h0FFF, "R2 capture control width");
    wr(7'h70, 32'hFFFF_FFFF); expect_reg(7'h70, 32'h000F, "R2 count mode width");
    wr(7'h2C, 32'h5555);      expect_reg(7'h2C, 32'h0, "R2 capture read-only");
    wr(7'h14, 0); wr(7'h28, 0); wr(7'h70, 0); wr(7'h0C, 0);
    for (int n = 0; n < 4; n++) wr(7'h18 + 7'(4*n), 0);

    // R11 hold
    wr(7'h04, 32'h3); idle(10);
    expect_reg(7'h08, 0, "R11 hold count");
    expect_reg(7'h10, 0, "R11 hold prescale count");

    // R3 disabled count stays put
    wr(7'h04, 0); wr(7'h08, 77); wr(7'h10, 3); idle(10);
    expect_reg(7'h08, 77, "R3 stopped count");
    expect_reg(7'h10, 3, "R3 stopped prescale count");

    // R4/R5 period sweep: flag 0 after (P+1)(M+1) clocks
    wr(7'h14, 32'h3);
    for (int p = 0; p < 4; p++) begin
      for (int m = 0; m < 4; m++) begin
        int cyc;
        wr(7'h04, 2); wr(7'h0C, p); wr(7'h18, m); wr(7'h00, 32'hFF);
        check(irq == 1'b0, "R10 irq low after clear", irq, 0);
        wr(7'h04, 1);
        cyc = 0;
        while (!irq && cyc < 200) begin
          @(posedge clk); #1; cyc++;
        end
        check(cyc == (p + 1) * (m + 1), "R4 R5 match period", cyc, (p + 1) * (m + 1));
        expect_reg(7'h08, 0, "R5 count zeroed on match");
        expect_reg(7'h00, 1, "R5 flag bit 0 only");
      end
    end
    wr(7'h04, 2); wr(7'h14, 0); wr(7'h0C, 0); wr(7'h18, 0); wr(7'h00, 32'hFF);

    // R6 stop on match
    wr(7'h1C, 5); wr(7'h14, 32'h20); wr(7'h04, 1); idle(20);
    expect_reg(7'h08, 5, "R6 count held at match");
    expect_reg(7'h04, 0, "R6 run bit cleared");
    check(irq == 1'b0, "R6 no flag without interrupt bit", irq, 0);
    wr(7'h14, 0); wr(7'h1C, 0);

    // R7 output actions: ch0 keep, ch1 clear, ch2 set, ch3 toggle
    wr(7'h04, 2); wr(7'h0C, 1);
    for (int n = 0; n < 4; n++) wr(7'h18 + 7'(4*n), 2);
    wr(7'h3C, 32'hE46);
    check(match_out == 4'b0110, "R7 written pin state", match_out, 4'b0110);
    wr(7'h14, 32'h4); wr(7'h04, 1); idle(20);
    check(match_out == 4'b1100, "R7 actions first hit", match_out, 4'b1100);
    wr(7'h04, 2); wr(7'h04, 1); idle(20);
    check(match_out == 4'b0100, "R7 actions second hit", match_out, 4'b0100);
    wr(7'h04, 2); wr(7'h04, 0); wr(7'h14, 0); wr(7'h3C, 0); wr(7'h0C, 0);
    for (int n = 0; n < 4; n++) wr(7'h18 + 7'(4*n), 0);
    wr(7'h00, 32'hFF);

    // R8 capture sweep, counter stopped
    for (int n = 0; n < 4; n++) begin
      logic [31:0] exp_cr;
      rd(7'h2C + 7'(4*n), exp_cr);
      for (int cfg = 0; cfg < 8; cfg++) begin
        logic [31:0] v1, v2;
        bit re, fe, ie;
        re = cfg[0]; fe = cfg[1]; ie = cfg[2];
        v1 = 32'(n * 100 + cfg * 10 + 1);
        v2 = v1 + 5;
        wr(7'h28, 32'(cfg) << (3 * n)); wr(7'h00, 32'hFF);
        wr(7'h08, v1);
        @(negedge clk) cap_in[n] = 1'b1;
        idle(5);
        if (re) exp_cr = v1;
        expect_reg(7'h2C + 7'(4*n), exp_cr, "R8 capture on rise");
        expect_reg(7'h00, (ie && re) ? (32'h10 << n) : 0, "R8 capture flag rise");
        wr(7'h08, v2);
        @(negedge clk) cap_in[n] = 1'b0;
        idle(5);
        if (fe) exp_cr = v2;
        expect_reg(7'h2C + 7'(4*n), exp_cr, "R8 capture on fall");
        expect_reg(7'h00, (ie && (re || fe)) ? (32'h10 << n) : 0, "R8 capture flag fall");
      end
    end
    wr(7'h28, 0); wr(7'h00, 32'hFF); wr(7'h08, 0);

    // R9 edge counting modes and source selection
    for (int mode = 1; mode < 4; mode++) begin
      for (int sel = 0; sel < 4; sel++) begin
        int e;
        wr(7'h04, 2); wr(7'h70, 32'((sel << 2) | mode)); wr(7'h04, 1);
        repeat (3) begin
          @(negedge clk) cap_in[sel] = 1'b1; idle(3);
          @(negedge clk) cap_in[sel] = 1'b0; idle(3);
        end
        repeat (2) begin
          @(negedge clk) cap_in[(sel + 1) % 4] = 1'b1; idle(3);
          @(negedge clk) cap_in[(sel + 1) % 4] = 1'b0; idle(3);
        end
        idle(4);
        e = (mode == 3) ? 6 : 3;
        expect_reg(7'h08, e, "R9 edge count");
      end
    end
    wr(7'h04, 2); wr(7'h70, 0); wr(7'h04, 0);

    // R10 write-one-to-clear
    wr(7'h28, 32'h5);
    @(negedge clk) cap_in[0] = 1'b1; idle(5);
    @(negedge clk) cap_in[0] = 1'b0;
    wr(7'h14, 32'h1); wr(7'h04, 1); idle(4); wr(7'h04, 0);
    expect_reg(7'h00, 32'h11, "R10 both flags pending");
    wr(7'h00, 32'h01);
    expect_reg(7'h00, 32'h10, "R10 clear bit 0 only");
    check(irq == 1'b1, "R10 irq with one flag", irq, 1);
    wr(7'h00, 32'h10);
    expect_reg(7'h00, 32'h0, "R10 all cleared");
    check(irq == 1'b0, "R10 irq low", irq, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule